// File: doc/BRIEF.md
# Programmable Skew Clock Output Bank

This block is the digital output stage of a clock buffer whose outputs can be shifted in time. It runs from a fast tap clock. One output period is N tap cycles, and a range selector picks N. The block builds four output pairs from a shared tap counter. Each pair has its own two-digit three-level control code, which selects a signed shift in whole taps, a divide-by-2 or divide-by-4 copy, or an inverted copy.

An edge-polarity input chooses which reference edge the outputs line up with. The reference is the tap counter's period start. A stop input parks outputs at their rest level, and it always spares pair 3 so that pair 3 can keep driving feedback. When a test selector is at MID, the stop input instead parks only the pairs whose code is LL. Parking and release take effect only while an output already sits at its rest level, so no runt pulses appear.

Top module: `skew_clock_bank`

## Requirements
- R1: A three-level digit is a 2-bit code: 00 means LOW, 01 means MID, 10 means HIGH, and 11 is read as MID. `rangeSel` sets N: LOW gives 44 taps, MID gives 26 and HIGH gives 16. If N shrinks so that the counter position is past the new period, the counter restarts at the period start.
- R2: Pair p (p = 1..4) takes its code from `pairSel[4p-1:4p-4]`, with the first digit in the upper two bits. Pair p drives `clkOut[2p-1:2p-2]`. Code MM gives the undelayed waveform, which is high for the first N/2 taps of each aligned period.
- R3: Pairs 1 and 2 map the codes LL, LM, LH, ML, MM, MH, HL, HM, HH to shifts of -4, -3, -2, -1, 0, +1, +2, +3 and +4 taps.
- R4: Pair 3 maps LL to divide-by-2, maps LM through HM to -6, -4, -2, 0, +2, +4 and +6 taps, and maps HH to divide-by-4.
- R5: Pair 4 uses the pair-3 map, except that HH gives the undelayed waveform inverted.
- R6: A shift of -k taps equals a delay of N-k taps, taken modulo the period.
- R7: With `edgePol` HIGH, the undelayed waveform rises at the period start. With `edgePol` LOW, it rises half a period later, which stands for the opposite reference edge.
- R8: Divided outputs change only at the aligned rising edge of the undelayed waveform. Every rising edge of the divide-by-4 output coincides with a rising edge of the divide-by-2 output. Both start high after reset.
- R9: With `outStop` HIGH and the test selector not at MID, pairs 1, 2 and 4 park at their rest level and pair 3 keeps running.
- R10: A pair parks or resumes only in a cycle where its running value equals its rest level, so no shortened high or low pulse appears.
- R11: The rest level is LOW, except for pair 4 in inverted mode, which rests at the level of `edgePol`.
- R12: With the test selector at MID and `outStop` HIGH, exactly the pairs whose code is LL are parked, pair 3 included.
- R13: During reset all outputs are LOW. The two outputs of a pair always carry the same waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tap clock |
| rstN | input | 1 | Active-low synchronous reset |
| rangeSel | input | 2 | Three-level range digit selecting N |
| testSel | input | 2 | Three-level test digit; only MID changes behaviour |
| outStop | input | 1 | Synchronous output stop request |
| edgePol | input | 1 | Reference edge choice: 1 rising, 0 falling |
| pairSel | input | 16 | Four 4-bit pair codes, two digits each |
| clkOut | output | 8 | Four output pairs |

## Verification
The bench walks every code of every pair through all three ranges and both edge polarities, so a wrong table entry or a negative shift wrapped the wrong way shows up as a waveform that is displaced by a few taps. It toggles the stop input at random cycles to catch an output that is cut mid-pulse, and it checks that pair 3 keeps running so a design that parks the feedback pair fails. Pair 4 in inverted mode is parked under both polarities, which exposes a rest level stuck LOW. Test-MID runs with mixed LL codes show whether a design parks too many or too few pairs. Shrinking the range while the counter sits high in a long period catches a counter that runs past the new period.

// File: rtl/skewbank_pkg.sv
package skewbank_pkg;

  localparam int TAP_W = 7;

  typedef enum logic [1:0] {
    MODE_SKEW = 2'd0,
    MODE_DIV2 = 2'd1,
    MODE_DIV4 = 2'd2,
    MODE_INV  = 2'd3
  } pairMode_e;

  typedef struct packed {
    logic [TAP_W-1:0] relPhase;
    logic [TAP_W-1:0] periodLen;
    logic [TAP_W-1:0] halfLen;
    logic [1:0]       epoch;
    logic             edgePol;
  } tapCtrl_t;

  // three-level digit: 00 low, 01 mid, 10 high, 11 folds to mid
  function automatic logic [1:0] normDigit(input logic [1:0] d);
    return (d == 2'b11) ? 2'b01 : d;
  endfunction

  // LL..HH -> 0..8
  function automatic logic [3:0] codeIndex(input logic [3:0] c);
    logic [3:0] hi;
    logic [3:0] lo;
    hi = {2'b00, normDigit(c[3:2])};
    lo = {2'b00, normDigit(c[1:0])};
    return hi * 4'd3 + lo;
  endfunction

endpackage

// File: rtl/skewbank_ctrl.sv
module skewbank_ctrl
  import skewbank_pkg::*;
#(
  parameter int TAPS_LO  = 44,
  parameter int TAPS_MID = 26,
  parameter int TAPS_HI  = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic [1:0] rangeSel,
  input  logic     edgePol,
  output tapCtrl_t tapCtrl
);

  logic [TAP_W-1:0] periodLen, halfLen, alignPhase;
  logic [TAP_W-1:0] phaseQ, phaseEff, relPhase;
  logic [TAP_W:0]   relSum;
  logic [1:0]       epochQ;

  always_comb begin
    case (normDigit(rangeSel))
      2'b00:   periodLen = TAP_W'(TAPS_LO);
      2'b01:   periodLen = TAP_W'(TAPS_MID);
      default: periodLen = TAP_W'(TAPS_HI);
    endcase
    halfLen    = periodLen >> 1;
    alignPhase = edgePol ? '0 : halfLen;
    phaseEff   = (phaseQ >= periodLen) ? '0 : phaseQ;
    relSum     = {1'b0, phaseEff} + {1'b0, periodLen} - {1'b0, alignPhase};
    relPhase   = (relSum >= {1'b0, periodLen}) ? TAP_W'(relSum - {1'b0, periodLen})
                                               : TAP_W'(relSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
      epochQ <= '0;
    end else begin
      phaseQ <= (phaseEff == periodLen - 1'b1) ? '0 : phaseEff + 1'b1;
      if (relPhase == periodLen - 1'b1) epochQ <= epochQ + 2'd1;
    end
  end

  assign tapCtrl = '{relPhase: relPhase, periodLen: periodLen, halfLen: halfLen,
                     epoch: epochQ, edgePol: edgePol};

  // R1: a position past a shrunken period restarts at the period start
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ >= periodLen) |=> (phaseQ == TAP_W'(1)));

  // R8: divided state only advances across the aligned period boundary
  p_epoch_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(epochQ) |-> ($past(relPhase) == $past(periodLen) - 1'b1));

endmodule

// File: rtl/skewbank_pair.sv
module skewbank_pair
  import skewbank_pkg::*;
#(
  parameter int PAIR_IDX = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  tapCtrl_t   tapCtrl,
  input  logic [3:0] pairCode,
  input  logic       stopReq,
  input  logic       testMid,
  output logic [1:0] pairOut
);

  logic [3:0]        codeIdx;
  pairMode_e         mode;
  logic signed [4:0] skewTaps;
  logic [4:0]        skewMag;
  logic [TAP_W-1:0]  delayTaps, skewPos;
  logic [TAP_W:0]    skewSum;
  logic              baseHi, rawLvl, restLvl, disReq;
  logic              enQ, outQ;

  assign codeIdx = codeIndex(pairCode);

  if (PAIR_IDX < 2) begin : g_fine
    always_comb begin
      mode     = MODE_SKEW;
      skewTaps = $signed({1'b0, codeIdx}) - 5'sd4;
    end
  end else begin : g_coarse
    logic signed [4:0] stepTaps;
    always_comb begin
      stepTaps = $signed({1'b0, codeIdx}) - 5'sd4;
      skewTaps = stepTaps <<< 1;
      if (codeIdx == 4'd0)      mode = MODE_DIV2;
      else if (codeIdx == 4'd8) mode = (PAIR_IDX == 3) ? MODE_INV : MODE_DIV4;
      else                      mode = MODE_SKEW;
    end
  end

  always_comb begin
    skewMag   = skewTaps[4] ? 5'(-skewTaps) : 5'(skewTaps);
    delayTaps = skewTaps[4] ? tapCtrl.periodLen - TAP_W'(skewMag) : TAP_W'(skewMag);
    skewSum   = {1'b0, tapCtrl.relPhase} + {1'b0, tapCtrl.periodLen} - {1'b0, delayTaps};
    skewPos   = (skewSum >= {1'b0, tapCtrl.periodLen})
                ? TAP_W'(skewSum - {1'b0, tapCtrl.periodLen}) : TAP_W'(skewSum);
    baseHi    = tapCtrl.relPhase < tapCtrl.halfLen;
    case (mode)
      MODE_SKEW: rawLvl = skewPos < tapCtrl.halfLen;
      MODE_DIV2: rawLvl = ~tapCtrl.epoch[0];
      MODE_DIV4: rawLvl = ~tapCtrl.epoch[1];
      default:   rawLvl = ~baseHi;
    endcase
    restLvl = (mode == MODE_INV) ? tapCtrl.edgePol : 1'b0;
    disReq  = stopReq && (testMid ? (codeIdx == 4'd0) : (PAIR_IDX != 2));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= 1'b1;
      outQ <= 1'b0;
    end else begin
      outQ <= enQ ? rawLvl : restLvl;
      if (rawLvl == restLvl) enQ <= ~disReq;
    end
  end

  assign pairOut = {outQ, outQ};

  // R10: resuming happens while the output sits at rest
  p_en_rise_rest_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enQ) |-> (outQ == $past(restLvl)));

  // R10: parking happens while the output sits at rest
  p_en_fall_rest_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enQ) |-> (outQ == $past(restLvl)));

  // R11: a parked inverted pair rests at the edge-polarity level
  p_inv_rest_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!enQ) && $past(mode == MODE_INV)) |-> (outQ == $past(tapCtrl.edgePol)));

endmodule

// File: rtl/skew_clock_bank.sv
module skew_clock_bank
  import skewbank_pkg::*;
#(
  parameter int TAPS_LO  = 44,
  parameter int TAPS_MID = 26,
  parameter int TAPS_HI  = 16,
  parameter int PAIRS    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           rangeSel,
  input  logic [1:0]           testSel,
  input  logic                 outStop,
  input  logic                 edgePol,
  input  logic [4*PAIRS-1:0]   pairSel,
  output logic [2*PAIRS-1:0]   clkOut
);

  tapCtrl_t tapCtrl;
  logic     testMid;

  assign testMid = (normDigit(testSel) == 2'b01);

  skewbank_ctrl #(
    .TAPS_LO (TAPS_LO),
    .TAPS_MID(TAPS_MID),
    .TAPS_HI (TAPS_HI)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rangeSel(rangeSel),
    .edgePol (edgePol),
    .tapCtrl (tapCtrl)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    skewbank_pair #(.PAIR_IDX(p)) u_pair (
      .clk     (clk),
      .rstN    (rstN),
      .tapCtrl (tapCtrl),
      .pairCode(pairSel[4*p +: 4]),
      .stopReq (outStop),
      .testMid (testMid),
      .pairOut (clkOut[2*p +: 2])
    );
  end

endmodule

// File: tb/sim_skew_clock_bank.sv
module sim_skew_clock_bank;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  rangeSel, testSel;
  logic        outStop, edgePol;
  logic [15:0] pairSel;
  logic [7:0]  clkOut;

  always #4 clk = ~clk;

  skew_clock_bank u0 (
    .clk(clk), .rstN(rstN), .rangeSel(rangeSel), .testSel(testSel),
    .outStop(outStop), .edgePol(edgePol), .pairSel(pairSel), .clkOut(clkOut)
  );

  int checks = 0;
  int fails  = 0;
  bit modelOn = 0;
  int mPh, mEp;
  bit mEn [4];
  logic [7:0] expOut;

  function automatic int dig(input logic [1:0] d);
    return (d == 2'b11) ? 1 : int'(d);
  endfunction

  function automatic int tapsOf(input logic [1:0] r);
    int v;
    v = dig(r);
    return (v == 0) ? 44 : (v == 1) ? 26 : 16;
  endfunction

  function automatic int idxOf(input logic [3:0] c);
    return dig(c[3:2]) * 3 + dig(c[1:0]);
  endfunction

  function automatic logic [3:0] codeOf(input int i);
    return {2'(i / 3), 2'(i % 3)};
  endfunction

  function automatic bit rawBit(input int p, input int i, input int rel, input int n, input int ep);
    int k, s;
    if (p < 2) k = i - 4;
    else if (i == 0) return (ep % 2) == 0;
    else if (i == 8) begin
      if (p == 3) return !(rel < n / 2);
      return ((ep / 2) % 2) == 0;
    end else k = 2 * (i - 4);
    s = ((rel - k) % n + n) % n;
    return s < n / 2;
  endfunction

  task automatic predict();
    int n, phE, align, rel;
    bit tm;
    n     = tapsOf(rangeSel);
    phE   = (mPh >= n) ? 0 : mPh;
    align = edgePol ? 0 : n / 2;
    rel   = (phE + n - align) % n;
    tm    = (dig(testSel) == 1);
    for (int p = 0; p < 4; p++) begin
      int i;
      bit raw, rest, dis, o;
      i    = idxOf(pairSel[4*p +: 4]);
      raw  = rawBit(p, i, rel, n, mEp);
      rest = (p == 3 && i == 8) ? edgePol : 1'b0;
      dis  = outStop && (tm ? (i == 0) : (p != 2));
      o    = mEn[p] ? raw : rest;
      expOut[2*p]   = o;
      expOut[2*p+1] = o;
      if (raw == rest) mEn[p] = !dis;
    end
    mPh = (phE == n - 1) ? 0 : phE + 1;
    if (rel == n - 1) mEp = (mEp + 1) % 4;
  endtask

  task automatic cmp(input string tag);
    if (modelOn) begin
      checks++;
      if (clkOut !== expOut) begin
        fails++;
        $display("FAIL %s: clkOut=%b expected %b at %0t", tag, clkOut, expOut, $time);
      end
    end
  endtask

  task automatic hold(input string tag, input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      cmp(tag);
      predict();
    end
  endtask

  task automatic setCfg(input string tag, input logic [1:0] r, input logic [1:0] t,
                        input logic s, input logic pe, input logic [15:0] sel);
    @(negedge clk);
    cmp(tag);
    rangeSel = r; testSel = t; outStop = s; edgePol = pe; pairSel = sel;
    predict();
  endtask

  task automatic randCfg(input string tag, input bit stopOften);
    logic [1:0] r, t;
    logic s;
    r = 2'($urandom % 4);
    t = ($urandom % 3 == 0) ? 2'b01 : 2'($urandom % 4);
    s = stopOften ? ($urandom % 2 == 0) : ($urandom % 5 == 0);
    setCfg(tag, r, t, s, 1'($urandom % 2), 16'($urandom));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seedV;
    logic [15:0] allMid;
    seedV  = $urandom(32'd4242);
    allMid = {4{4'b0101}};
    rstN = 1'b0; rangeSel = 2'b01; testSel = 2'b00; outStop = 1'b0;
    edgePol = 1'b1; pairSel = allMid;
    repeat (3) @(negedge clk);
    // R13: outputs low during reset
    checks++;
    if (clkOut !== 8'h00) begin
      fails++;
      $display("FAIL R13: clkOut=%b expected %b", clkOut, 8'h00);
    end
    rstN = 1'b1;
    mPh = 0; mEp = 0;
    for (int p = 0; p < 4; p++) mEn[p] = 1'b1;
    modelOn = 1;
    predict();
    hold("R2", 60);
    // R2: undriven-code 11 reads as MID
    setCfg("R2", 2'b11, 2'b00, 0, 1, {4{4'b1111}});
    hold("R2", 60);
    // R1: each range, then shrink while counter is deep in a long period
    setCfg("R1", 2'b00, 2'b00, 0, 1, allMid);
    hold("R1", 80);
    setCfg("R1", 2'b10, 2'b00, 0, 1, allMid);
    hold("R1", 40);
    setCfg("R1", 2'b01, 2'b00, 0, 1, allMid);
    hold("R1", 60);
    // R3, R4, R5: every code on every pair, each range
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 9; i++) begin
        setCfg("R3", 2'(r), 2'b00, 0, 1, {codeOf(8 - i), codeOf(8 - i), codeOf(i), codeOf(i)});
        hold("R3", 50);
        setCfg("R4", 2'(r), 2'b00, 0, 1, {allMid[15:12], codeOf(i), allMid[7:0]});
        hold("R4", 180);
        setCfg("R5", 2'(r), 2'b00, 0, 0, {codeOf(i), allMid[11:0]});
        hold("R5", 180);
      end
    end
    // R6: most negative shifts at the shortest period
    setCfg("R6", 2'b10, 2'b00, 0, 1, {codeOf(1), codeOf(1), codeOf(0), codeOf(0)});
    hold("R6", 64);
    // R7: polarity swaps
    for (int k = 0; k < 6; k++) begin
      setCfg("R7", 2'(k % 3), 2'b00, 0, 1'(k % 2), {codeOf(8), codeOf(4), codeOf(2), codeOf(6)});
      hold("R7", 70);
    end
    // R8: divided outputs under falling-edge alignment
    setCfg("R8", 2'b10, 2'b00, 0, 0, {codeOf(0), codeOf(8), allMid[7:0]});
    hold("R8", 200);
    // R9: stop spares pair 3
    setCfg("R9", 2'b01, 2'b00, 1, 1, {codeOf(3), codeOf(5), codeOf(2), codeOf(7)});
    hold("R9", 120);
    setCfg("R9", 2'b01, 2'b00, 0, 1, {codeOf(3), codeOf(5), codeOf(2), codeOf(7)});
    hold("R9", 60);
    // R11: inverted pair parked under both polarities
    setCfg("R11", 2'b10, 2'b10, 1, 1, {codeOf(8), allMid[11:0]});
    hold("R11", 50);
    setCfg("R11", 2'b10, 2'b10, 1, 0, {codeOf(8), allMid[11:0]});
    hold("R11", 50);
    setCfg("R11", 2'b10, 2'b10, 0, 0, {codeOf(8), allMid[11:0]});
    hold("R11", 40);
    // R12: test MID parks only LL pairs
    setCfg("R12", 2'b01, 2'b01, 1, 1, {codeOf(4), codeOf(0), codeOf(0), codeOf(2)});
    hold("R12", 120);
    setCfg("R12", 2'b00, 2'b11, 1, 0, {codeOf(0), codeOf(8), codeOf(5), codeOf(0)});
    hold("R12", 120);
    // R10: stop toggled at random points, random codes
    for (int k = 0; k < 300; k++) begin
      randCfg("R10", 1);
      hold("R10", 1 + int'($urandom % 40));
    end
    // R13: long random run also compares pair outputs bit by bit
    for (int k = 0; k < 200; k++) begin
      randCfg("R13", 0);
      hold("R13", 20 + int'($urandom % 100));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule